// File: doc/BRIEF.md
# Per-Bunch Interleaved Eight-Tap FIR Filter

This block filters the position samples of every bunch in a storage ring separately. Samples arrive four at a time, one per lane. Each clock cycle carries the samples of one group of four adjacent bunches, which this project calls a slot. The caller supplies the slot index with every group. For each bunch the filter keeps the seven samples that the same bunch produced on earlier turns. Each tap delay is therefore one full revolution of that bunch, not one clock cycle.

The seven history values of all four bunches in a slot live in a dual-port memory, one word per slot and lane. The word is read when the sample enters. It is written back one stage later, moved along by one position, with the new sample at the front. Eight signed coefficients are shared by all bunches and are loaded through a write-only configuration port. Each bunch produces an exact 36-bit two's-complement result, which a later gain and saturation stage consumes.

Top module: `bunch_fir`

## Requirements
- R1: After reset, out_valid is low, out_data is zero, all eight coefficients are zero and every slot's history reads as zero. A reset applied later clears the history of every slot again.
- R2: A sample group presented with in_valid high at a rising edge yields out_valid high after the second rising edge that follows. out_valid is low in every other cycle.
- R3: Each lane result is y = sum over k = 0..7 of coef[k] * x(n-k). Here x(n) is the sample just presented and x(n-k) is the sample that the same lane and slot received k valid presentations earlier. A history position older than the number of samples received since reset counts as zero.
- R4: Lane L takes its sample from in_data[16L+15:16L] and returns its result on out_data[36L+35:36L]. Bunch number slot*LANES+L has its own history, which no other lane or slot disturbs. in_slot must stay below NUM_BUNCH/LANES while in_valid is high.
- R5: Cycles with in_valid low shift no history and change no state apart from out_valid.
- R6: When the same slot is presented on two consecutive cycles, the second sample sees the first as its one-revolution-old value.
- R7: A write with cfg_we high and cfg_addr equal to 0x200 + 0x10*k, for k = 0..7, loads cfg_wdata as the signed coefficient k. The new value applies to a sample presented in the same cycle and to all later samples.
- R8: A configuration write to any other address is ignored. This includes addresses with a nonzero low nibble, addresses below 0x200 and addresses at or above 0x280.
- R9: The result never wraps: with all coefficients at -32768 and eight samples of -32768, the output is +2^33 (36'h2_0000_0000).
- R10: out_data keeps its last value during cycles in which out_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A sample group is present this cycle |
| in_slot | input | SLOT_W | Slot index (group of LANES bunches) |
| in_data | input | LANES*16 | One signed 16-bit sample per lane |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 12 | Configuration byte address |
| cfg_wdata | input | 16 | Coefficient value, signed |
| out_valid | output | 1 | Result group valid |
| out_data | output | LANES*36 | One signed 36-bit result per lane |

## Verification
The bench builds the filter with 8 bunches and 4 lanes, so a revolution is only two slots long. The full seven-deep history of a bunch therefore fills within a few dozen cycles, and an impulse can be followed through every tap. The short revolution also makes the same slot appear back to back naturally, which reaches the forwarding path between the write-back and the next read. Coefficient changes, ignored writes, idle gaps and full-scale operands are all checked against a sequential model that moves each bunch's history one sample at a time.

// File: rtl/bunch_fir_pkg.sv
package bunch_fir_pkg;

    // Coefficient k sits at COEF_BASE + (k << COEF_STEP_SH).
    localparam int unsigned COEF_BASE    = 32'h200;
    localparam int unsigned COEF_STEP_SH = 4;

    // Returns the coefficient index selected by a byte address, or -1.
    function automatic int coef_index(input int unsigned addr, input int unsigned taps);
        int unsigned off;
        if (addr < COEF_BASE) return -1;
        off = addr - COEF_BASE;
        if ((off & ((32'd1 << COEF_STEP_SH) - 32'd1)) != 32'd0) return -1;
        if ((off >> COEF_STEP_SH) >= taps) return -1;
        return int'(off >> COEF_STEP_SH);
    endfunction

endpackage

// File: rtl/bunch_fir_coef_bank.sv
module bunch_fir_coef_bank
    import bunch_fir_pkg::*;
#(
    parameter int TAPS   = 8,
    parameter int COEF_W = 16,
    parameter int CFG_AW = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [CFG_AW-1:0]        cfg_addr,
    input  logic [COEF_W-1:0]        cfg_wdata,
    output logic [TAPS*COEF_W-1:0]   coef_flat
);
    localparam int IDX_W = (TAPS > 1) ? $clog2(TAPS) : 1;

    typedef struct packed {
        logic [TAPS-1:0][COEF_W-1:0] coef;
    } bank_t;

    bank_t             bank_d, bank_q;
    int                sel;
    logic              hit;
    logic [IDX_W-1:0]  sel_idx;

    always_comb begin
        sel     = coef_index(32'(cfg_addr), TAPS);
        hit     = cfg_we && (sel >= 0);
        sel_idx = sel[IDX_W-1:0];
        bank_d  = bank_q;
        if (hit) bank_d.coef[sel_idx] = cfg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign coef_flat = bank_q.coef;

    // R7: a decoded write lands in the addressed coefficient
    a_r7_coef_load: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> bank_q.coef[$past(sel_idx)] == $past(cfg_wdata));

    // R8: a write to any other address leaves every coefficient alone
    a_r8_ignore_stray: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !hit) |=> $stable(bank_q.coef));

endmodule

// File: rtl/bunch_fir_hist_ram.sv
module bunch_fir_hist_ram #(
    parameter int DEPTH  = 120,
    parameter int WORD_W = 112,
    parameter int AW     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data_q,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data
);
    logic [WORD_W-1:0] mem_q [DEPTH];
    logic              fwd;

    assign fwd = wr_en && (wr_addr == rd_addr);

    // Write port and registered read port; a same-address write is forwarded.
    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_addr] <= wr_data;
        if (rd_en) rd_data_q <= fwd ? wr_data : mem_q[rd_addr];
    end

    // R6: a read colliding with a write returns the word being written
    a_r6_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && fwd) |=> rd_data_q == $past(wr_data));

endmodule

// File: rtl/bunch_fir_lane_mac.sv
module bunch_fir_lane_mac #(
    parameter int TAPS     = 8,
    parameter int SAMPLE_W = 16,
    parameter int COEF_W   = 16,
    parameter int ACC_W    = 36
) (
    input  logic [SAMPLE_W-1:0]          x,
    input  logic [(TAPS-1)*SAMPLE_W-1:0] hist,
    input  logic [TAPS*COEF_W-1:0]       coef_flat,
    output logic [ACC_W-1:0]             y
);
    localparam int PROD_W = SAMPLE_W + COEF_W;

    logic signed [PROD_W-1:0] prod [TAPS];
    logic signed [ACC_W-1:0]  acc;

    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        logic [SAMPLE_W-1:0] tap_val;
        if (t == 0) begin : g_now
            assign tap_val = x;
        end else begin : g_old
            assign tap_val = hist[(t-1)*SAMPLE_W +: SAMPLE_W];
        end
        assign prod[t] = $signed(tap_val) * $signed(coef_flat[t*COEF_W +: COEF_W]);
    end

    // Products are sign-extended to the accumulator width before summing.
    always_comb begin
        acc = '0;
        for (int t = 0; t < TAPS; t++) acc = acc + ACC_W'(prod[t]);
        y = acc;
    end

endmodule

// File: rtl/bunch_fir.sv
module bunch_fir #(
    parameter int NUM_BUNCH = 480,
    parameter int LANES     = 4,
    parameter int TAPS      = 8,
    parameter int SAMPLE_W  = 16,
    parameter int COEF_W    = 16,
    parameter int ACC_W     = 36,
    parameter int CFG_AW    = 12,
    localparam int SLOTS    = NUM_BUNCH / LANES,
    localparam int SLOT_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [SLOT_W-1:0]         in_slot,
    input  logic [LANES*SAMPLE_W-1:0] in_data,
    input  logic                      cfg_we,
    input  logic [CFG_AW-1:0]         cfg_addr,
    input  logic [COEF_W-1:0]         cfg_wdata,
    output logic                      out_valid,
    output logic [LANES*ACC_W-1:0]    out_data
);
    localparam int HIST   = TAPS - 1;
    localparam int WORD_W = HIST * SAMPLE_W;

    typedef struct packed {
        logic                      s1_valid;
        logic [SLOT_W-1:0]         s1_slot;
        logic [LANES*SAMPLE_W-1:0] s1_x;
        logic                      s1_seen;
        logic [SLOTS-1:0]          seen;
        logic                      out_valid;
        logic [LANES*ACC_W-1:0]    out_data;
    } state_t;

    state_t                    st_d, st_q;
    logic [TAPS*COEF_W-1:0]    coef_flat;
    logic [LANES*ACC_W-1:0]    sum_flat;

    bunch_fir_coef_bank #(
        .TAPS(TAPS), .COEF_W(COEF_W), .CFG_AW(CFG_AW)
    ) u_coef (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .coef_flat(coef_flat)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [WORD_W-1:0]   rd_word;
        logic [WORD_W-1:0]   hist_eff;
        logic [WORD_W-1:0]   wr_word;
        logic [SAMPLE_W-1:0] x_lane;

        assign x_lane   = st_q.s1_x[l*SAMPLE_W +: SAMPLE_W];
        // A slot untouched since reset has an all-zero history.
        assign hist_eff = st_q.s1_seen ? rd_word : '0;
        if (HIST > 1) begin : g_shift
            assign wr_word = {hist_eff[WORD_W-SAMPLE_W-1:0], x_lane};
        end else begin : g_single
            assign wr_word = x_lane;
        end

        bunch_fir_hist_ram #(
            .DEPTH(SLOTS), .WORD_W(WORD_W), .AW(SLOT_W)
        ) u_hist (
            .clk(clk), .rst_n(rst_n),
            .rd_en(in_valid), .rd_addr(in_slot), .rd_data_q(rd_word),
            .wr_en(st_q.s1_valid), .wr_addr(st_q.s1_slot), .wr_data(wr_word)
        );

        bunch_fir_lane_mac #(
            .TAPS(TAPS), .SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .ACC_W(ACC_W)
        ) u_mac (
            .x(x_lane), .hist(hist_eff), .coef_flat(coef_flat),
            .y(sum_flat[l*ACC_W +: ACC_W])
        );
    end

    always_comb begin
        st_d          = st_q;
        st_d.s1_valid = in_valid;
        if (in_valid) begin
            st_d.s1_slot = in_slot;
            st_d.s1_x    = in_data;
            st_d.s1_seen = st_q.seen[in_slot]
                         | (st_q.s1_valid && (st_q.s1_slot == in_slot));
        end
        if (st_q.s1_valid) st_d.seen[st_q.s1_slot] = 1'b1;
        st_d.out_valid = st_q.s1_valid;
        if (st_q.s1_valid) st_d.out_data = sum_flat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.out_valid;
    assign out_data  = st_q.out_data;

    // R2: every accepted group yields a result two edges later
    a_r2_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    // R2: no result without a group two edges earlier
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));

    // R4: slot index stays within one revolution
    a_r4_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (32'(in_slot) < SLOTS));

    // R10: the result bus holds while no group is in the compute stage
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.s1_valid |=> $stable(out_data));

endmodule

// File: tb/bunch_fir_tb.sv
module bunch_fir_tb;
    localparam int NB = 8;
    localparam int LN = 4;
    localparam int SL = NB / LN;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [0:0]    in_slot = '0;
    logic [63:0]   in_data = '0;
    logic          cfg_we = 1'b0;
    logic [11:0]   cfg_addr = '0;
    logic [15:0]   cfg_wdata = '0;
    logic          out_valid;
    logic [143:0]  out_data;

    int total = 0;
    int bad = 0;

    longint coef_m [8];
    longint hist_m [SL][LN][7];
    bit     seen_m [SL];

    bit           p_v [2];
    logic [143:0] p_d [2];
    string        p_tag [2];
    logic [143:0] last_exp;
    logic [31:0]  lfsr = 32'h1234_5678;

    always #10 clk = ~clk;

    bunch_fir #(.NUM_BUNCH(NB), .LANES(LN)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_slot(in_slot),
        .in_data(in_data), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .out_valid(out_valid), .out_data(out_data)
    );

    task automatic check_bit(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic check_vec(input string tag, input logic [143:0] act, input logic [143:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic void clear_model();
        for (int k = 0; k < 8; k++) coef_m[k] = 0;
        for (int s = 0; s < SL; s++) begin
            seen_m[s] = 1'b0;
            for (int l = 0; l < LN; l++)
                for (int k = 0; k < 7; k++) hist_m[s][l][k] = 0;
        end
        p_v[0] = 1'b0; p_v[1] = 1'b0;
        last_exp = '0;
    endfunction

    // One cycle: check the result due now, update model, drive inputs.
    task automatic step(input bit v, input int slot, input logic [63:0] data,
                        input bit we, input int addr, input logic [15:0] wd,
                        input string tag);
        logic [143:0] exp_word;
        @(negedge clk);
        check_bit("R2 out_valid", out_valid, p_v[1]);
        if (p_v[1]) begin
            check_vec(p_tag[1], out_data, p_d[1]);
            last_exp = p_d[1];
        end else begin
            check_vec("R10 hold", out_data, last_exp);
        end
        if (we && addr >= 'h200 && addr < 'h280 && (addr % 16) == 0)
            coef_m[(addr - 'h200) / 16] = longint'($signed(wd));
        exp_word = '0;
        if (v) begin
            for (int l = 0; l < LN; l++) begin
                longint x;
                longint y;
                x = longint'($signed(data[16*l +: 16]));
                y = coef_m[0] * x;
                for (int k = 1; k < 8; k++) y += coef_m[k] * hist_m[slot][l][k-1];
                for (int k = 6; k > 0; k--) hist_m[slot][l][k] = hist_m[slot][l][k-1];
                hist_m[slot][l][0] = x;
                exp_word[36*l +: 36] = y[35:0];
            end
            seen_m[slot] = 1'b1;
        end
        p_v[1] = p_v[0]; p_d[1] = p_d[0]; p_tag[1] = p_tag[0];
        p_v[0] = v; p_d[0] = exp_word; p_tag[0] = tag;
        in_valid  = v;
        in_slot   = 1'(slot);
        in_data   = data;
        cfg_we    = we;
        cfg_addr  = 12'(addr);
        cfg_wdata = wd;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, '0, 0, 0, '0, "idle");
    endtask

    task automatic wr_coef(input int k, input logic [15:0] val);
        step(0, 0, '0, 1, 'h200 + 16*k, val, "R7 write");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; cfg_we = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        clear_model();
        check_bit("R1 out_valid after reset", out_valid, 1'b0);
        check_vec("R1 out_data after reset", out_data, '0);
    endtask

    // R1: reset state, coefficients zero, history zero
    task automatic t_reset_state();
        do_reset();
        step(1, 0, 64'h7fff_8000_1234_0001, 0, 0, '0, "R1 zero coefs");
        idle(2);
    endtask

    // R3/R4: impulse on slot 0 walks through every tap; slot 1 runs alongside
    task automatic t_impulse();
        logic [15:0] cv [8] = '{16'd3, -16'sd5, 16'd7, -16'sd11, 16'd13, -16'sd17, 16'd19, -16'sd23};
        for (int k = 0; k < 8; k++) wr_coef(k, cv[k]);
        step(1, 0, {16'd100, -16'sd1, 16'd2, 16'd1}, 0, 0, '0, "R1 R3 impulse first");
        step(1, 1, {16'd10, 16'd10, 16'd10, 16'd10}, 0, 0, '0, "R4 other slot");
        for (int t = 0; t < 8; t++) begin
            step(1, 0, '0, 0, 0, '0, "R3 impulse tap");
            step(1, 1, {16'd10, -16'sd20, 16'd30, -16'sd40}, 0, 0, '0, "R4 other slot");
        end
        idle(2);
    endtask

    // R5: idle cycles between samples do not move history
    task automatic t_gaps();
        step(1, 1, {16'd5, 16'd6, 16'd7, 16'd8}, 0, 0, '0, "R5 before gap");
        idle(3);
        step(1, 1, {16'd1, 16'd1, 16'd1, 16'd1}, 0, 0, '0, "R5 after gap");
        idle(4);
        step(1, 1, '0, 0, 0, '0, "R5 after long gap");
        idle(2);
    endtask

    // R6: same slot on consecutive cycles uses the forwarded word
    task automatic t_forward();
        for (int i = 0; i < 9; i++)
            step(1, 0, {16'(i*3), 16'(-i), 16'(i+100), 16'(7*i)}, 0, 0, '0, "R6 back to back");
        idle(2);
    endtask

    // R7: a write in the same cycle as a sample applies to that sample
    task automatic t_coef_same_cycle();
        step(1, 1, {16'd2, 16'd3, 16'd4, 16'd5}, 1, 'h200, 16'd1000, "R7 same cycle c0");
        step(1, 0, {16'd9, 16'd8, 16'd7, 16'd6}, 1, 'h270, -16'sd300, "R7 same cycle c7");
        step(1, 1, {16'd1, 16'd1, 16'd1, 16'd1}, 0, 0, '0, "R7 after write");
        idle(2);
    endtask

    // R8: stray addresses are ignored
    task automatic t_ignored();
        step(1, 0, {16'd4, 16'd4, 16'd4, 16'd4}, 1, 'h208, 16'h5555, "R8 low nibble");
        step(1, 1, {16'd3, 16'd3, 16'd3, 16'd3}, 1, 'h280, 16'h5555, "R8 above range");
        step(1, 0, {16'd2, 16'd2, 16'd2, 16'd2}, 1, 'h1f0, 16'h5555, "R8 below range");
        step(1, 1, {16'd1, 16'd1, 16'd1, 16'd1}, 1, 'h000, 16'h5555, "R8 zero address");
        step(1, 0, {16'd1, 16'd1, 16'd1, 16'd1}, 0, 0, '0, "R8 after strays");
        idle(2);
    endtask

    // R9: full-scale operands, no wrap
    task automatic t_fullscale();
        for (int k = 0; k < 8; k++) wr_coef(k, 16'h8000);
        for (int i = 0; i < 8; i++)
            step(1, 1, {16'h8000, 16'h7fff, 16'h8000, 16'h8000}, 0, 0, '0, "R9 full scale");
        idle(2);
        check_vec("R9 plus 2^33", 144'(out_data[35:0]), 144'(36'h2_0000_0000));
    endtask

    // R4: pseudo-random traffic across lanes and slots
    task automatic t_mixed();
        for (int k = 0; k < 8; k++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            wr_coef(k, lfsr[15:0]);
        end
        for (int i = 0; i < 40; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step(lfsr[3:0] != 4'd0, int'(lfsr[5]), {lfsr, lfsr ^ 32'h9e37_79b9},
                 0, 0, '0, "R4 mixed");
        end
        idle(2);
    endtask

    // R1: a later reset clears every slot's history and the coefficients
    task automatic t_rereset();
        do_reset();
        wr_coef(0, 16'd2);
        wr_coef(1, 16'd50);
        step(1, 0, {16'd11, 16'd12, 16'd13, 16'd14}, 0, 0, '0, "R1 history cleared");
        step(1, 1, {16'd21, 16'd22, 16'd23, 16'd24}, 0, 0, '0, "R1 history cleared");
        idle(3);
    endtask

    initial begin
        clear_model();
        repeat (3) @(negedge clk);
        t_reset_state();
        t_impulse();
        t_gaps();
        t_forward();
        t_coef_same_cycle();
        t_ignored();
        t_fullscale();
        t_mixed();
        t_rereset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule